// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This block holds two independent 16-bit up-counters behind a small 16-bit register bus. Each counter advances once per prescaled tick. The tick comes from the system clock divided by one of four power-of-two ratios. When a running counter reaches its compare value on a tick, the counter returns to zero and counting continues. If the channel's interrupt enable is set, that channel's interrupt line pulses high for one clock.

Software starts and stops both channels through one shared run register. It sets the divide ratio and the interrupt enable in a per-channel control register. It can load the counter and the compare value at any time. A typical use is a periodic tick source: load the compare value with the period minus one, pick a divide ratio, set the enable and start the channel.

Top module: `match_timer_pair`

## Requirements
- R1: After reset the run register reads 0, both control registers read 0, both counters read 0, both compare registers read 0xFFFF, and both interrupt lines are low.
- R2: In the run register (byte offset 0), bit 0 runs channel 0 and bit 1 runs channel 1. A read returns those two bits and zero in every other bit.
- R3: In a control register, bits [1:0] select the divide ratio and bit 6 is the interrupt enable. Only these bits are stored: writing 0xFFFF reads back as 0x0043. Channel 0's control register is at byte offset 2 and channel 1's is at byte offset 8.
- R4: A divide code s gives a tick every 8·4^s clocks (8, 32, 128, 512). Suppose the start write is captured at clock edge 0 and nothing else intervenes. Then after edge k the count has advanced by floor(k / divide). The first increment therefore needs a full divide period.
- R5: On a tick where the counter equals the compare value, the counter becomes 0 instead of incrementing. With compare value C the counter cycles through 0..C, and one cycle spans (C+1)·divide clocks. Counters are at byte offsets 4 and 10; compare registers are at byte offsets 6 and 12.
- R6: Each match with the enable set gives exactly one one-clock high pulse on that channel's interrupt line, in the clock after the match edge. With the enable clear, a match gives no pulse.
- R7: A stopped channel holds its count. A counter read returns the live count, whether the channel is running or stopped. Stopping a channel clears its divider, so a restart again needs a full divide period before the first increment.
- R8: Running, matching and register writes on one channel leave the other channel's count and interrupt line untouched.
- R9: Suppose software writes a counter in the same clock as a tick or a match on that channel. The written value wins, and that match produces no interrupt pulse.
- R10: A counter loaded above its compare value counts up through 0xFFFF, wraps to 0 with no interrupt, and then reaches the compare value normally.
- R11: The word at byte offsets 14/15 reads as 0, and writes to it change no register.
- R12: A read presented in one clock returns its data in the next clock, and that data holds until the next read. Address bit 0 is ignored, so offsets 2n and 2n+1 reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one clock per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid one clock after a read |
| irq | output | 2 | Per-channel one-clock match interrupt pulse |

## Verification
Internal faults in this block show up as counter values or interrupt counts that differ from simple arithmetic on the clock count. A divider that is off by one, or that is not cleared on stop, moves the count by one tick within a single divide period of a start. The bench stops a channel after an exactly known number of clocks and reads the held count, so such a fault appears in the first read. A fault in match or clear logic shows within one compare period, either as a count outside 0..C or as a missing or extra interrupt pulse. The bench sweeps every divide code on both channels with compare values of 0 and 2, and also covers the load-versus-tick collision and the wrap above the compare value.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  // Channel count and address layout are tied together: 16-byte window,
  // one word for the run register, then three words per channel.
  localparam int NCH         = 2;
  localparam int ADDR_W      = 4;
  localparam int WORD_W      = ADDR_W - 1;
  localparam int SEL_W       = 2;
  localparam int IE_BIT      = 6;
  localparam int REGS_PER_CH = 3;

  localparam logic [WORD_W-1:0] W_RUN = '0;

  typedef enum int {
    K_CTL = 0,
    K_CNT = 1,
    K_CMP = 2
  } chreg_e;

  // Word index of register k of channel ch.
  function automatic logic [WORD_W-1:0] ch_word(input int ch, input int k);
    ch_word = WORD_W'(1 + REGS_PER_CH * ch + k);
  endfunction
endpackage

// File: rtl/mtp_prescaler.sv
module mtp_prescaler #(
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;
  localparam int PW   = BASE_SHIFT + STEP_SHIFT * (NSEL - 1);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  // Terminal count for the selected ratio: 2^(BASE + STEP*sel) - 1.
  always_comb begin
    limit = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (sel == SEL_W'(i))
        limit = PW'((64'd1 << (BASE_SHIFT + STEP_SHIFT * i)) - 64'd1);
    end
  end

  // >= keeps a ratio change mid-period from waiting for a full wrap.
  assign tick = run && (pcnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)
      pcnt_q <= '0;
    else if (tick)
      pcnt_q <= '0;
    else
      pcnt_q <= pcnt_q + PW'(1);
  end
endmodule

// File: rtl/mtp_channel.sv
module mtp_channel #(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 2,
  parameter int IE_BIT     = 6,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ctl_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ie_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q;
  logic             irq_q;
  logic             tick;
  logic             hit;

  mtp_prescaler #(
    .BASE_SHIFT(BASE_SHIFT),
    .STEP_SHIFT(STEP_SHIFT),
    .SEL_W     (SEL_W)
  ) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .sel (sel_q),
    .tick(tick)
  );

  assign hit = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
      cmp_q <= '1;
    end else begin
      if (ctl_we) begin
        sel_q <= wdata[SEL_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (cmp_we)
        cmp_q <= wdata;
    end
  end

  // Software load wins over the hardware tick and suppresses its pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit && ie_q && !cnt_we;
      if (cnt_we)
        cnt_q <= wdata;
      else if (hit)
        cnt_q <= '0;
      else if (tick)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign sel_o = sel_q;
  assign ie_o  = ie_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mtp_busif.sv
module mtp_busif
  import mtp_pkg::*;
#(
  parameter int NCH_P  = 2,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid,
  input  logic                        write,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NCH_P-1:0][DATA_W-1:0] cnt_i,
  input  logic [NCH_P-1:0][DATA_W-1:0] cmp_i,
  input  logic [NCH_P-1:0][SEL_W-1:0] sel_i,
  input  logic [NCH_P-1:0]            ie_i,
  output logic [NCH_P-1:0]            run_o,
  output logic [NCH_P-1:0]            ctl_we_o,
  output logic [NCH_P-1:0]            cnt_we_o,
  output logic [NCH_P-1:0]            cmp_we_o,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [ADDR_W-1:0] addr_sh;
  logic [WORD_W-1:0] word;
  logic              wr;
  logic              rd;
  logic [NCH_P-1:0]  run_q;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;

  // 16-bit accesses only: the byte-select bit plays no part.
  assign addr_sh = addr >> 1;
  assign word    = addr_sh[WORD_W-1:0];
  assign wr      = valid && write;
  assign rd      = valid && !write;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= '0;
    else if (wr && word == W_RUN)
      run_q <= wdata[NCH_P-1:0];
  end

  for (genvar c = 0; c < NCH_P; c++) begin : g_strobe
    assign ctl_we_o[c] = wr && (word == ch_word(c, K_CTL));
    assign cnt_we_o[c] = wr && (word == ch_word(c, K_CNT));
    assign cmp_we_o[c] = wr && (word == ch_word(c, K_CMP));
  end

  always_comb begin
    rmux = '0;
    if (word == W_RUN)
      rmux[NCH_P-1:0] = run_q;
    for (int c = 0; c < NCH_P; c++) begin
      if (word == ch_word(c, K_CTL)) begin
        rmux[SEL_W-1:0] = sel_i[c];
        rmux[IE_BIT]    = ie_i[c];
      end
      if (word == ch_word(c, K_CNT))
        rmux = cnt_i[c];
      if (word == ch_word(c, K_CMP))
        rmux = cmp_i[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd)
      rdata_q <= rmux;
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/match_timer_pair.sv
module match_timer_pair
  import mtp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0]            run_w;
  logic [NCH-1:0]            ctl_we_w;
  logic [NCH-1:0]            cnt_we_w;
  logic [NCH-1:0]            cmp_we_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [NCH-1:0][CNT_W-1:0] cmp_w;
  logic [NCH-1:0][SEL_W-1:0] sel_w;
  logic [NCH-1:0]            ie_w;

  mtp_busif #(
    .NCH_P (NCH),
    .DATA_W(CNT_W)
  ) u_bus (
    .clk     (clk),
    .rst     (rst),
    .valid   (bus_valid),
    .write   (bus_write),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .cnt_i   (cnt_w),
    .cmp_i   (cmp_w),
    .sel_i   (sel_w),
    .ie_i    (ie_w),
    .run_o   (run_w),
    .ctl_we_o(ctl_we_w),
    .cnt_we_o(cnt_we_w),
    .cmp_we_o(cmp_we_w),
    .rdata_o (bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mtp_channel #(
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W),
      .IE_BIT    (IE_BIT),
      .BASE_SHIFT(BASE_SHIFT),
      .STEP_SHIFT(STEP_SHIFT)
    ) u_ch (
      .clk   (clk),
      .rst   (rst),
      .run   (run_w[c]),
      .ctl_we(ctl_we_w[c]),
      .cnt_we(cnt_we_w[c]),
      .cmp_we(cmp_we_w[c]),
      .wdata (bus_wdata),
      .cnt_o (cnt_w[c]),
      .cmp_o (cmp_w[c]),
      .sel_o (sel_w[c]),
      .ie_o  (ie_w[c]),
      .irq_o (irq[c])
    );
  end
endmodule

// File: rtl/mtp_checker.sv
module mtp_checker
  import mtp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [CNT_W-1:0]          bus_rdata,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            ie,
  input logic [NCH-1:0]            cnt_we,
  input logic [NCH-1:0][CNT_W-1:0] cnt
);
  logic rd_undef;
  logic rd_run;
  assign rd_undef = bus_valid && !bus_write && (bus_addr[ADDR_W-1:1] == '1);
  assign rd_run   = bus_valid && !bus_write && (bus_addr[ADDR_W-1:1] == '0);

  assert_undef_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rd_undef) |-> (bus_rdata == '0));

  assert_run_read_mask_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_run) |-> (bus_rdata[CNT_W-1:NCH] == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
      irq[c] |=> !irq[c]);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> $past(ie[c]));

    assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(run[c]) && !$past(cnt_we[c])) |-> $stable(cnt[c]));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(run[c]) && !$past(cnt_we[c])) |->
        (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) + CNT_W'(1) || cnt[c] == '0));
  end
endmodule

bind match_timer_pair mtp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .run      (run_w),
  .ie       (ie_w),
  .cnt_we   (cnt_we_w),
  .cnt      (cnt_w)
);

// File: tb/match_timer_pair_test.sv
module match_timer_pair_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;
  int irq_seen [2] = '{0, 0};

  match_timer_pair uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (irq[0]) irq_seen[0]++;
      if (irq[1]) irq_seen[1]++;
    end
  end

  function automatic logic [3:0] a_ctl(int c); return 4'(2 + 6*c); endfunction
  function automatic logic [3:0] a_cnt(int c); return 4'(4 + 6*c); endfunction
  function automatic logic [3:0] a_cmp(int c); return 4'(6 + 6*c); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  // Start write at edge 0, stop write captured at edge n.
  task automatic run_ch(int c, int n);
    wr(4'd0, 16'(1 << c));
    repeat (n - 1) @(negedge clk);
    wr(4'd0, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(4'd0, v); check("R1 run", v, 0);
    for (int c = 0; c < 2; c++) begin
      rd(a_ctl(c), v); check("R1 ctl", v, 0);
      rd(a_cnt(c), v); check("R1 cnt", v, 0);
      rd(a_cmp(c), v); check("R1 cmp", v, 16'hFFFF);
    end
    check("R1 irq", irq, 0);

    // R2: run register keeps two bits
    wr(4'd0, 16'hFFFF); rd(4'd0, v); check("R2 run mask", v, 16'h0003);
    wr(4'd0, 16'h0000); rd(4'd0, v); check("R2 run clear", v, 0);

    // R3: control register writable bits
    wr(a_ctl(1), 16'hFFFF); rd(a_ctl(1), v); check("R3 ctl mask", v, 16'h0043);
    wr(a_ctl(1), 16'h0000); rd(a_ctl(1), v); check("R3 ctl clear", v, 0);

    // R4/R5/R6/R8: sweep divide codes, compare values, enables, channels
    for (int c = 0; c < 2; c++) begin
      for (int code = 0; code < 4; code++) begin
        for (int ci = 0; ci < 2; ci++) begin
          int cm = (ci == 0) ? 0 : 2;
          int ie = (code + ci + c) % 2;
          int dv = 8 << (2 * code);
          int n  = dv * (cm + 1) * 2 + dv / 2 + 3;
          int base_me;
          int base_other;
          logic [15:0] other_before;
          wr(a_cnt(c), 16'h0000);
          wr(a_cmp(c), 16'(cm));
          wr(a_ctl(c), 16'(code | (ie << 6)));
          rd(a_cnt(1 - c), other_before);
          base_me = irq_seen[c];
          base_other = irq_seen[1 - c];
          run_ch(c, n);
          rd(a_cnt(c), v);
          check("R4 R5 count after run", v, 32'((n / dv) % (cm + 1)));
          check("R6 pulse count", irq_seen[c] - base_me, ie ? n / (dv * (cm + 1)) : 0);
          rd(a_cnt(1 - c), v);
          check("R8 other count", v, other_before);
          check("R8 other irq", irq_seen[1 - c] - base_other, 0);
        end
      end
    end

    // R7: live read while running, hold while stopped, divider restart
    wr(a_ctl(0), 16'h0000); wr(a_cmp(0), 16'hFFFF); wr(a_cnt(0), 16'h0000);
    wr(4'd0, 16'h0001);
    repeat (19) @(negedge clk);
    rd(a_cnt(0), v); check("R7 live read", v, 2);
    wr(4'd0, 16'h0000);
    rd(a_cnt(0), v);
    repeat (40) @(negedge clk);
    rd(a_cnt(0), v2); check("R7 hold", v2, v);
    wr(a_cnt(0), 16'h0000);
    run_ch(0, 5); run_ch(0, 5);
    rd(a_cnt(0), v); check("R7 divider restart", v, 0);
    run_ch(0, 8);
    rd(a_cnt(0), v); check("R7 full period", v, 1);

    // R9: software load at a match edge wins and kills the pulse
    begin
      int b0;
      wr(a_cmp(0), 16'h0000); wr(a_ctl(0), 16'h0040); wr(a_cnt(0), 16'h0000);
      b0 = irq_seen[0];
      wr(4'd0, 16'h0001);
      repeat (7) @(negedge clk);
      wr(a_cnt(0), 16'h0055);
      repeat (7) @(negedge clk);
      wr(4'd0, 16'h0000);
      rd(a_cnt(0), v); check("R9 load wins", v, 16'h0056);
      check("R9 no pulse", irq_seen[0] - b0, 0);
    end

    // R10: counter above compare wraps without a pulse
    begin
      int b0;
      wr(a_cmp(0), 16'h0003); wr(a_cnt(0), 16'hFFFE);
      b0 = irq_seen[0];
      run_ch(0, 24);
      rd(a_cnt(0), v); check("R10 wrap", v, 1);
      check("R10 no pulse", irq_seen[0] - b0, 0);
    end

    // R11: undefined word
    wr(4'd14, 16'hFFFF); wr(4'd15, 16'hFFFF);
    rd(4'd14, v); check("R11 read zero", v, 0);
    rd(4'd0, v); check("R11 run untouched", v, 0);
    rd(a_cmp(0), v); check("R11 cmp untouched", v, 16'h0003);
    rd(a_cnt(0), v); check("R11 cnt untouched", v, 1);

    // R12: byte bit ignored, read data holds
    rd(4'd7, v); check("R12 odd address", v, 16'h0003);
    wr(a_cmp(1), 16'h1234);
    repeat (5) @(negedge clk);
    check("R12 rdata holds", bus_rdata, 16'h0003);
    rd(4'd13, v); check("R12 odd address ch1", v, 16'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule